// File: doc/BRIEF.md
# Instruction Cache Base Controller

This block holds the anchor address and the per-line valid flags of a small on-chip instruction cache. It also acts on the one-byte, operand-free opcode that re-anchors the cache to the running code.

When that opcode executes, the program counter is rounded down to a line boundary. If the rounded address already equals the stored base, nothing in the cache changes. Otherwise the base takes the new address and every valid flag drops in the same edge. The same opcode always clears the three prefix-state flags (B, ALT1, ALT2), so that decode returns to its default mode. The arithmetic status flags live elsewhere and are not touched.

A fetch unit reports completed line fills, and each report sets the valid flag of that line. For any fetch address the block reports, combinationally, whether the byte is held in a valid line (a one-cycle fetch) or must come from ROM/RAM (a slow fetch of three or four cycles). It also reports the line index the address falls into.

Top module: `icache_anchor_ctrl`

## Requirements
- R1: Only a cycle with `op_valid` high and `op_code` equal to 8'h02 executes the re-anchor operation; any other opcode, or the strobe low, leaves the base and the valid flags as they were.
- R2: The candidate base is `pc` with its low 4 bits forced to zero (pc AND 16'hFFF0), so the base is always a multiple of 16.
- R3: If the candidate equals the stored base, executing the operation changes neither the base nor any valid flag.
- R4: If the candidate differs from the stored base, the next clock edge loads the candidate into the base and clears all 32 valid flags.
- R5: Executing the operation clears `pfx_b`, `pfx_alt1` and `pfx_alt2` at the next edge, whether or not the base changes, and wins over a set request in the same cycle.
- R6: Outside an execution, a high `pfx_set_b`, `pfx_set_alt1` or `pfx_set_alt2` sets the matching flag at the next edge, and the flag then holds.
- R7: A high `fill_valid` sets valid flag `fill_line` (bit n of `line_valid` is line n) at the next edge.
- R8: A fill in the same cycle as a base-changing execution is lost (the flush wins); a fill in the same cycle as a non-changing execution still takes effect.
- R9: With offset = (`fetch_addr` - base) mod 2^16, `fetch_line` is offset bits [8:4], and `fetch_hit` is 1 exactly when offset < 512 and that line's valid flag is set; addresses below the base wrap to a large offset and miss.
- R10: Synchronous reset sets the base to 16'h0000 and clears all valid flags and the three prefix flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 8 | Opcode byte being executed |
| pc | input | 16 | Program counter at execution |
| pfx_set_b | input | 1 | Request to set the B flag |
| pfx_set_alt1 | input | 1 | Request to set the ALT1 flag |
| pfx_set_alt2 | input | 1 | Request to set the ALT2 flag |
| fill_valid | input | 1 | Line-fill-complete strobe |
| fill_line | input | 5 | Index of the filled line |
| fetch_addr | input | 16 | Address being fetched |
| cache_base | output | 16 | Current cache base |
| line_valid | output | 32 | Per-line valid flags |
| fetch_hit | output | 1 | 1 = one-cycle cache fetch, 0 = slow ROM/RAM fetch |
| fetch_line | output | 5 | Line index of `fetch_addr` relative to the base |
| pfx_b | output | 1 | B flag |
| pfx_alt1 | output | 1 | ALT1 flag |
| pfx_alt2 | output | 1 | ALT2 flag |

## Verification
The bench builds the block at its default parameters: 16-bit addresses and 32 lines of 16 bytes. With these values the span of 512 bytes is smaller than the address space, so the range-compare variant of the hit logic is the one elaborated. Both edges of the window can be reached: the last byte of line 31 and the first byte past the span. The wrap below the base, seen as a huge offset, can also be reached. Line indices 0 and 31 are both filled, so the end bits of the valid vector and the opcode match on 8'h02 against its neighbour 8'h03 are exercised.

// File: rtl/icache_anchor_pkg.sv
package icache_anchor_pkg;

   // Prefix-mode state held alongside the cache control
   typedef struct packed {
      logic b;
      logic alt1;
      logic alt2;
   } pfx_t;

   localparam pfx_t PFX_CLEAR = '{b: 1'b0, alt1: 1'b0, alt2: 1'b0};

endpackage

// File: rtl/anchor_base_reg.sv
module anchor_base_reg #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              exec,
   input  logic [ADDR_W-1:0] pc,
   output logic [ADDR_W-1:0] base,
   output logic              differ
);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = {ADDR_W{1'b1}} << OFF_W;

   logic [ADDR_W-1:0] cand;

   if (OFF_W >= ADDR_W) begin : g_bad_off
      $error("anchor_base_reg: OFF_W must be below ADDR_W");
   end

   assign cand   = pc & ALIGN_MASK;
   assign differ = (cand != base);

   always_ff @(posedge clk) begin
      if (rst)
         base <= '0;
      else if (exec && differ)
         base <= cand;
   end

   AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      (base & ~ALIGN_MASK) == '0);                                   // R2
   AST_BASE_IDLE: assert property (@(posedge clk) disable iff (rst)
      !exec |=> $stable(base));                                      // R1
   AST_BASE_MATCH_KEEP: assert property (@(posedge clk) disable iff (rst)
      (exec && (pc & ALIGN_MASK) == base) |=> $stable(base));        // R3
   AST_BASE_RELOAD: assert property (@(posedge clk) disable iff (rst)
      (exec && (pc & ALIGN_MASK) != base) |=> base == ($past(pc) & ALIGN_MASK)); // R4

endmodule

// File: rtl/line_valid_array.sv
module line_valid_array #(
   parameter int NUM_LINES = 32,
   localparam int IDX_W    = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 flush,
   input  logic                 fill_valid,
   input  logic [IDX_W-1:0]     fill_line,
   output logic [NUM_LINES-1:0] valid
);

   if (NUM_LINES < 2 || (1 << IDX_W) != NUM_LINES) begin : g_bad_lines
      $error("line_valid_array: NUM_LINES must be a power of two >= 2");
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      logic set_this;
      assign set_this = fill_valid && (fill_line == IDX_W'(i));
      always_ff @(posedge clk) begin
         if (rst || flush)
            valid[i] <= 1'b0;
         else if (set_this)
            valid[i] <= 1'b1;
      end
   end

   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
      flush |=> valid == '0);                                        // R4
   AST_FILL_SETS: assert property (@(posedge clk) disable iff (rst)
      (fill_valid && !flush) |=> valid[$past(fill_line)]);           // R7
   AST_FLUSH_BEATS_FILL: assert property (@(posedge clk) disable iff (rst)
      (fill_valid && flush) |=> !valid[$past(fill_line)]);           // R8
   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
      !flush |=> ((valid & $past(valid)) == $past(valid)));          // R7

endmodule

// File: rtl/fetch_hit_check.sv
module fetch_hit_check #(
   parameter int ADDR_W     = 16,
   parameter int OFF_W      = 4,
   parameter int NUM_LINES  = 32,
   localparam int IDX_W     = $clog2(NUM_LINES),
   localparam int SPAN_BITS = OFF_W + IDX_W
) (
   input  logic [ADDR_W-1:0]    base,
   input  logic [NUM_LINES-1:0] valid,
   input  logic [ADDR_W-1:0]    fetch_addr,
   output logic                 hit,
   output logic [IDX_W-1:0]     line
);
   logic [ADDR_W-1:0] offset;
   logic              in_span;

   assign offset = fetch_addr - base;
   assign line   = offset[OFF_W +: IDX_W];

   if (SPAN_BITS > ADDR_W) begin : g_bad_span
      $error("fetch_hit_check: cache span exceeds the address space");
   end else if (SPAN_BITS == ADDR_W) begin : g_full_span
      // Cache covers every address: any offset is inside the window
      assign in_span = 1'b1;
   end else begin : g_part_span
      assign in_span = (offset[ADDR_W-1:SPAN_BITS] == '0);
   end

   assign hit = in_span && valid[line];

endmodule

// File: rtl/prefix_state.sv
module prefix_state
   import icache_anchor_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic exec,
   input  pfx_t set_req,
   output pfx_t state
);

   always_ff @(posedge clk) begin
      if (rst || exec)
         state <= PFX_CLEAR;
      else
         state <= state | set_req;
   end

   AST_EXEC_CLEARS_PFX: assert property (@(posedge clk) disable iff (rst)
      exec |=> state == PFX_CLEAR);                                  // R5
   AST_PFX_SET: assert property (@(posedge clk) disable iff (rst)
      (!exec && set_req.alt1) |=> state.alt1);                       // R6
   AST_PFX_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!exec && state.b) |=> state.b);                               // R6

endmodule

// File: rtl/icache_anchor_ctrl.sv
module icache_anchor_ctrl
   import icache_anchor_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter int          LINE_BYTES = 16,
   parameter int          NUM_LINES  = 32,
   parameter logic [7:0]  ANCHOR_OP  = 8'h02,
   localparam int         OFF_W      = $clog2(LINE_BYTES),
   localparam int         IDX_W      = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 op_valid,
   input  logic [7:0]           op_code,
   input  logic [ADDR_W-1:0]    pc,
   input  logic                 pfx_set_b,
   input  logic                 pfx_set_alt1,
   input  logic                 pfx_set_alt2,
   input  logic                 fill_valid,
   input  logic [IDX_W-1:0]     fill_line,
   input  logic [ADDR_W-1:0]    fetch_addr,
   output logic [ADDR_W-1:0]    cache_base,
   output logic [NUM_LINES-1:0] line_valid,
   output logic                 fetch_hit,
   output logic [IDX_W-1:0]     fetch_line,
   output logic                 pfx_b,
   output logic                 pfx_alt1,
   output logic                 pfx_alt2
);

   if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_line_bytes
      $error("icache_anchor_ctrl: LINE_BYTES must be a power of two");
   end

   logic exec;
   logic differ;
   logic flush;
   pfx_t pfx_req;
   pfx_t pfx_q;

   assign exec    = op_valid && (op_code == ANCHOR_OP);
   assign flush   = exec && differ;
   assign pfx_req = '{b: pfx_set_b, alt1: pfx_set_alt1, alt2: pfx_set_alt2};

   anchor_base_reg #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_base (
      .clk    (clk),
      .rst    (rst),
      .exec   (exec),
      .pc     (pc),
      .base   (cache_base),
      .differ (differ)
   );

   line_valid_array #(.NUM_LINES(NUM_LINES)) u_valid (
      .clk        (clk),
      .rst        (rst),
      .flush      (flush),
      .fill_valid (fill_valid),
      .fill_line  (fill_line),
      .valid      (line_valid)
   );

   fetch_hit_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .NUM_LINES(NUM_LINES)) u_hit (
      .base       (cache_base),
      .valid      (line_valid),
      .fetch_addr (fetch_addr),
      .hit        (fetch_hit),
      .line       (fetch_line)
   );

   prefix_state u_pfx (
      .clk     (clk),
      .rst     (rst),
      .exec    (exec),
      .set_req (pfx_req),
      .state   (pfx_q)
   );

   assign pfx_b    = pfx_q.b;
   assign pfx_alt1 = pfx_q.alt1;
   assign pfx_alt2 = pfx_q.alt2;

   AST_OTHER_OP_INERT: assert property (@(posedge clk) disable iff (rst)
      (op_code != ANCHOR_OP) |=> ($stable(cache_base) &&
         ($past(line_valid) & ~line_valid) == '0));                   // R1
   AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
      fetch_hit |-> line_valid[fetch_line]);                          // R9
   AST_RESET_STATE: assert property (@(posedge clk)
      rst |=> (cache_base == '0 && line_valid == '0 &&
               !pfx_b && !pfx_alt1 && !pfx_alt2));                    // R10

endmodule

// File: tb/icache_anchor_ctrl_tb.sv
module icache_anchor_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst;
   logic        op_valid;
   logic [7:0]  op_code;
   logic [15:0] pc;
   logic        pfx_set_b, pfx_set_alt1, pfx_set_alt2;
   logic        fill_valid;
   logic [4:0]  fill_line;
   logic [15:0] fetch_addr;
   logic [15:0] cache_base;
   logic [31:0] line_valid;
   logic        fetch_hit;
   logic [4:0]  fetch_line;
   logic        pfx_b, pfx_alt1, pfx_alt2;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   icache_anchor_ctrl u_dut (
      .clk, .rst, .op_valid, .op_code, .pc,
      .pfx_set_b, .pfx_set_alt1, .pfx_set_alt2,
      .fill_valid, .fill_line, .fetch_addr,
      .cache_base, .line_valid, .fetch_hit, .fetch_line,
      .pfx_b, .pfx_alt1, .pfx_alt2
   );

   // exec, pc, fill, fill_line, expected base, expected valid
   localparam int NV = 8;
   localparam logic [70:0] VEC [NV] = '{
      {1'b0, 16'h0000, 1'b1, 5'd0,  16'h0000, 32'h0000_0001},  // R7
      {1'b0, 16'h0000, 1'b1, 5'd31, 16'h0000, 32'h8000_0001},  // R7
      {1'b1, 16'h0007, 1'b0, 5'd0,  16'h0000, 32'h8000_0001},  // R3
      {1'b1, 16'h1234, 1'b0, 5'd0,  16'h1230, 32'h0000_0000},  // R2 R4
      {1'b0, 16'h0000, 1'b1, 5'd3,  16'h1230, 32'h0000_0008},  // R7
      {1'b1, 16'h123F, 1'b1, 5'd5,  16'h1230, 32'h0000_0028},  // R8 keep
      {1'b1, 16'h2000, 1'b1, 5'd7,  16'h2000, 32'h0000_0000},  // R8 flush
      {1'b0, 16'h0000, 1'b1, 5'd2,  16'h2000, 32'h0000_0004}   // R7
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      op_valid = 1'b0; op_code = 8'h00; pc = 16'h0000;
      pfx_set_b = 1'b0; pfx_set_alt1 = 1'b0; pfx_set_alt2 = 1'b0;
      fill_valid = 1'b0; fill_line = 5'd0;
   endtask

   // inputs are set at the falling edge; one rising edge applies them
   task automatic tick();
      @(posedge clk);
      #2;
      idle_inputs();
   endtask

   task automatic probe(input logic [15:0] a, input logic exp_hit, input logic [4:0] exp_line,
                        input string req);
      fetch_addr = a;
      #1;
      chk(req, {31'd0, fetch_hit}, {31'd0, exp_hit});
      chk(req, {27'd0, fetch_line}, {27'd0, exp_line});
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      fetch_addr = 16'h0000;
      rst = 1'b1;
      @(negedge clk); pfx_set_b = 1'b1; fill_valid = 1'b1; fill_line = 5'd4;
      @(posedge clk); #2;
      chk("R10 base", {16'd0, cache_base}, 32'h0);
      chk("R10 valid", line_valid, 32'h0);
      chk("R10 pfx", {29'd0, pfx_b, pfx_alt1, pfx_alt2}, 32'h0);
      idle_inputs();
      @(negedge clk); rst = 1'b0;

      // table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         op_valid   = VEC[i][70];
         op_code    = 8'h02;
         pc         = VEC[i][69:54];
         fill_valid = VEC[i][53];
         fill_line  = VEC[i][52:48];
         tick();
         chk($sformatf("R4 base step %0d", i), {16'd0, cache_base}, {16'd0, VEC[i][47:32]});
         chk($sformatf("R8 valid step %0d", i), line_valid, VEC[i][31:0]);
      end

      // R1: a neighbouring opcode with a different pc does nothing
      @(negedge clk); op_valid = 1'b1; op_code = 8'h03; pc = 16'h4560; tick();
      chk("R1 base", {16'd0, cache_base}, 32'h0000_2000);
      chk("R1 valid", line_valid, 32'h0000_0004);
      // R1: right opcode, strobe low
      @(negedge clk); op_valid = 1'b0; op_code = 8'h02; pc = 16'h4560; tick();
      chk("R1 strobe", {16'd0, cache_base}, 32'h0000_2000);

      // R6: set requests
      @(negedge clk); pfx_set_b = 1'b1; pfx_set_alt1 = 1'b1; tick();
      @(negedge clk); pfx_set_alt2 = 1'b1; tick();
      chk("R6 pfx set", {29'd0, pfx_b, pfx_alt1, pfx_alt2}, 32'h7);
      // R5: matching exec (no base change) still clears prefixes
      @(negedge clk); op_valid = 1'b1; op_code = 8'h02; pc = 16'h2009; tick();
      chk("R5 pfx clear", {29'd0, pfx_b, pfx_alt1, pfx_alt2}, 32'h0);
      chk("R3 valid kept", line_valid, 32'h0000_0004);
      // R5: exec wins over simultaneous set
      @(negedge clk); op_valid = 1'b1; op_code = 8'h02; pc = 16'h2000;
      pfx_set_b = 1'b1; pfx_set_alt1 = 1'b1; pfx_set_alt2 = 1'b1; tick();
      chk("R5 exec beats set", {29'd0, pfx_b, pfx_alt1, pfx_alt2}, 32'h0);

      // R9: hit window with base 0x2000, line 2 valid; add line 31
      @(negedge clk); fill_valid = 1'b1; fill_line = 5'd31; tick();
      probe(16'h2020, 1'b1, 5'd2,  "R9 first byte line 2");
      probe(16'h202F, 1'b1, 5'd2,  "R9 last byte line 2");
      probe(16'h2030, 1'b0, 5'd3,  "R9 invalid line 3");
      probe(16'h21FF, 1'b1, 5'd31, "R9 end of span");
      probe(16'h2200, 1'b0, 5'd0,  "R9 past span");
      probe(16'h1FFF, 1'b0, 5'd31, "R9 below base wraps");

      // R10: reset mid-run
      @(negedge clk); rst = 1'b1; tick();
      chk("R10 reset base", {16'd0, cache_base}, 32'h0);
      chk("R10 reset valid", line_valid, 32'h0);
      rst = 1'b0;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule